// File: doc/BRIEF.md
# CAN Message Object Buffer RAM

This block is the 256-byte message and register store that sits between a CPU and the receive side of a CAN protocol engine. The CPU reaches every byte through a byte-wide port with a combinational read path and a clocked write. The protocol engine uses a separate deposit port. In one clock cycle it writes a whole 15-byte frame image into a chosen message object. The block decodes the address map into four kinds of location: global registers, message-object bytes, three control registers that live in the spare top bytes of objects 3, 4 and 5, and reserved holes.

Objects 1 to 14 hold one frame each. A new deposit replaces the old frame, and if the old one was still unread the object records a lost message. Object 15 only receives, and it keeps two buffers. The CPU always reads the visible buffer. A later frame waits in the other buffer until the CPU gives a one-cycle release strobe. If yet another frame arrives, it replaces the waiting frame and the buffer being read is left alone. The two bit-timing registers accept writes only while the configuration-enable bit of the control register is set.

Top module: `can_msg_ram`

## Requirements
- R1: After reset, the control register (0x00) reads 0x01. Every other global register, both bit-timing registers, the interrupt register and byte 0 of every object read 0x00.
- R2: Offsets 0x01 and 0x06–0x0F are CPU read/write registers. Byte k (0 to 14) of object n (1 to 15) is at offset n·16+k. A CPU write there is read back unchanged, except bits 7:6 of byte 0.
- R3: Offsets 0x02–0x05 and the top byte of every object except 3, 4 and 5 (0x1F, 0x2F, 0x6F…0xFF) always read 0x00, and CPU writes to them are discarded.
- R4: A CPU write to bit-timing register 0 (0x3F) or 1 (0x4F) takes effect only while bit 6 of the control register is 1. Otherwise the register keeps its value. The interrupt register (0x5F) is always writable.
- R5: A deposit to object 1–14 stores dep_img byte k (bits 8k+7:8k) as object byte k, readable in the next cycle, and sets the new-data flag (byte 0 bit 6). Image bits 7:6 of byte 0 are not stored.
- R6: A deposit to an object 1–14 whose new-data flag is already 1 replaces the frame and sets the lost flag (byte 0 bit 7). A deposit while new-data is 0 leaves the lost flag unchanged.
- R7: A CPU write to byte 0 of an object 1–14 clears the lost flag when data bit 7 is 0 and clears new-data when data bit 6 is 0. A 1 in either bit leaves that flag unchanged.
- R8: For object 15, the first frame becomes visible (byte 0 bit 6 = 1). A second frame goes to the other buffer, and CPU reads keep returning the first frame.
- R9: o15_rel makes a waiting frame visible. With no frame waiting, it clears object 15's byte 0 bit 6.
- R10: A frame for object 15 that arrives while both buffers are full replaces the waiting frame, leaves the visible frame intact and sets object 15's lost flag (byte 0 bit 7). A CPU write of bit 7 = 0 to 0xF0 clears that flag.
- R11: A deposit with dep_tx = 1 for object 15 drives dep_rej high in the same cycle and changes nothing. With dep_tx = 1, objects 1–14 accept the deposit as usual.
- R12: When the CPU and the deposit port write the same object in the same cycle, the deposited image wins.
- R13: A deposit that names object 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | CPU byte offset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational from cpu_addr) |
| o15_rel | input | 1 | One-cycle strobe: CPU has finished reading object 15 |
| dep_valid | input | 1 | Deposit request |
| dep_obj | input | 4 | Target object of the deposit |
| dep_tx | input | 1 | Deposit is tagged as a transmit-direction request |
| dep_img | input | 120 | Frame image, byte k in bits 8k+7:8k |
| dep_rej | output | 1 | Deposit refused (transmit request to object 15) |

## Verification
The assertions check the flag and buffer-state rules on every cycle:
- a locked bit-timing register holds its value, and an unlocked one takes the written data;
- reserved offsets read zero;
- object 15 never has a waiting frame without a visible one;
- a rejected deposit leaves object 15 untouched;
- a release with a frame waiting swaps buffers;
- overwriting unread data always sets the lost flag.

Whether the right frame bytes arrive at the right offsets can only be shown by the bench's scenarios. The same holds for the alternating buffer order over a sequence of several frames and releases, for deposit priority in a same-cycle collision, and for reads of the flags after they are cleared.

// File: rtl/can_mram_pkg.sv
package can_mram_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int SLOT_W    = 4;
  localparam int OBJ_BYTES = 15;
  localparam int OBJ_LAST  = 15;
  localparam int IMG_W     = OBJ_BYTES * DATA_W;

  typedef enum logic [2:0] {
    RG_RSVD, RG_GLOB, RG_OBJ, RG_BT0, RG_BT1, RG_INTR
  } region_e;

  typedef struct packed {
    region_e             rg;
    logic [SLOT_W-1:0]   slot;
    logic [SLOT_W-1:0]   byt;
  } dec_t;

  // Fixed map: slot 0 = globals, spare top byte of slots 3/4/5 = timing/interrupt.
  function automatic dec_t map_addr(input logic [ADDR_W-1:0] a);
    dec_t d;
    d.slot = a[ADDR_W-1 -: SLOT_W];
    d.byt  = a[SLOT_W-1:0];
    d.rg   = RG_RSVD;
    if (d.slot == '0) begin
      if (d.byt == 4'd0 || d.byt == 4'd1 || d.byt >= 4'd6) d.rg = RG_GLOB;
    end else if (d.byt != 4'hF) begin
      d.rg = RG_OBJ;
    end else begin
      case (d.slot)
        4'd3:    d.rg = RG_BT0;
        4'd4:    d.rg = RG_BT1;
        4'd5:    d.rg = RG_INTR;
        default: d.rg = RG_RSVD;
      endcase
    end
    return d;
  endfunction

  // A flag survives a CPU write only where the written bit is 1.
  function automatic logic flag_keep(input logic flag, input logic wbit);
    return flag & wbit;
  endfunction

  // Byte 0 as the CPU sees it: lost, new-data, six stored bits.
  function automatic logic [DATA_W-1:0] status_byte(input logic lost, input logic fresh,
                                                    input logic [DATA_W-1:0] raw);
    return {lost, fresh, raw[DATA_W-3:0]};
  endfunction
endpackage

// File: rtl/can_mram_glob.sv
module can_mram_glob
  import can_mram_pkg::*;
#(
  parameter int               CCE_BIT  = 6,
  parameter logic [DATA_W-1:0] CTRL_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  region_e           rg,
  input  logic [SLOT_W-1:0] byt,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] bt0_q,
  output logic [DATA_W-1:0] bt1_q,
  output logic              bt_blocked
);
  localparam int GLOB_N = 1 << SLOT_W;

  logic [DATA_W-1:0] gl [GLOB_N];
  logic [DATA_W-1:0] intr_q;
  logic              bt_open;
  logic              bt_wr;

  assign bt_open    = gl[0][CCE_BIT];
  assign bt_wr      = cpu_wr && (rg == RG_BT0 || rg == RG_BT1);
  assign bt_blocked = bt_wr && !bt_open;
  assign ctrl_q     = gl[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < GLOB_N; i++) gl[i] <= (i == 0) ? CTRL_RST : '0;
      bt0_q  <= '0;
      bt1_q  <= '0;
      intr_q <= '0;
    end else if (cpu_wr) begin
      case (rg)
        RG_GLOB: gl[byt] <= wdata;
        RG_BT0:  if (bt_open) bt0_q <= wdata;
        RG_BT1:  if (bt_open) bt1_q <= wdata;
        RG_INTR: intr_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rg)
      RG_GLOB: rdata = gl[byt];
      RG_BT0:  rdata = bt0_q;
      RG_BT1:  rdata = bt1_q;
      RG_INTR: rdata = intr_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/can_mram_sobj.sv
module can_mram_sobj
  import can_mram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [SLOT_W-1:0] byt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dep_we,
  input  logic [IMG_W-1:0]  dep_img,
  output logic [DATA_W-1:0] rdata,
  output logic              new_o,
  output logic              lost_o,
  output logic              ovr_ev
);
  logic [DATA_W-1:0] mem [OBJ_BYTES];
  logic              new_q, lost_q;

  assign ovr_ev = dep_we && new_q;
  assign new_o  = new_q;
  assign lost_o = lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < OBJ_BYTES; i++) mem[i] <= '0;
      new_q  <= 1'b0;
      lost_q <= 1'b0;
    end else if (dep_we) begin
      for (int i = 0; i < OBJ_BYTES; i++) mem[i] <= dep_img[i*DATA_W +: DATA_W];
      new_q  <= 1'b1;
      lost_q <= lost_q | new_q;
    end else if (cpu_we) begin
      if (byt == '0) begin
        mem[0] <= wdata;
        lost_q <= flag_keep(lost_q, wdata[DATA_W-1]);
        new_q  <= flag_keep(new_q, wdata[DATA_W-2]);
      end else if (byt < SLOT_W'(OBJ_BYTES)) begin
        mem[byt] <= wdata;
      end
    end
  end

  always_comb begin
    if (byt == '0)                         rdata = status_byte(lost_q, new_q, mem[0]);
    else if (byt < SLOT_W'(OBJ_BYTES))     rdata = mem[byt];
    else                                   rdata = '0;
  end
endmodule

// File: rtl/can_mram_o15.sv
module can_mram_o15
  import can_mram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [SLOT_W-1:0] byt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rel,
  input  logic              dep_we,
  input  logic [IMG_W-1:0]  dep_img,
  output logic [DATA_W-1:0] rdata,
  output logic              vis_o,
  output logic              vf_o,
  output logic              pf_o,
  output logic              lost_o,
  output logic              swap_ev,
  output logic              ovr_ev
);
  logic [DATA_W-1:0] mem [2][OBJ_BYTES];
  logic vis, vf, pf, lost_q;
  logic r_vis, r_vf, r_pf;
  logic tgt, n_vf, n_pf;
  logic cpu_ok;

  // Release is applied first, then the deposit is placed against that state.
  assign r_vis   = (rel && pf) ? ~vis : vis;
  assign r_vf    = rel ? pf : vf;
  assign r_pf    = rel ? 1'b0 : pf;
  assign swap_ev = rel && pf;

  always_comb begin
    n_vf   = r_vf;
    n_pf   = r_pf;
    tgt    = r_vis;
    ovr_ev = 1'b0;
    if (dep_we) begin
      if (!r_vf) begin
        n_vf = 1'b1;
      end else begin
        tgt    = ~r_vis;
        n_pf   = 1'b1;
        ovr_ev = r_pf;
      end
    end
  end

  assign cpu_ok = cpu_we && !(dep_we && tgt == vis) && (byt < SLOT_W'(OBJ_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < OBJ_BYTES; i++) mem[b][i] <= '0;
      vis    <= 1'b0;
      vf     <= 1'b0;
      pf     <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      vis <= r_vis;
      vf  <= n_vf;
      pf  <= n_pf;
      if (dep_we)
        for (int i = 0; i < OBJ_BYTES; i++) mem[tgt][i] <= dep_img[i*DATA_W +: DATA_W];
      if (cpu_ok) mem[vis][byt] <= wdata;
      if (ovr_ev)
        lost_q <= 1'b1;
      else if (cpu_we && byt == '0)
        lost_q <= flag_keep(lost_q, wdata[DATA_W-1]);
    end
  end

  always_comb begin
    if (byt == '0)                     rdata = status_byte(lost_q, vf, mem[vis][0]);
    else if (byt < SLOT_W'(OBJ_BYTES)) rdata = mem[vis][byt];
    else                               rdata = '0;
  end

  assign vis_o  = vis;
  assign vf_o   = vf;
  assign pf_o   = pf;
  assign lost_o = lost_q;
endmodule

// File: rtl/can_msg_ram.sv
module can_msg_ram
  import can_mram_pkg::*;
#(
  parameter int               CCE_BIT  = 6,
  parameter logic [DATA_W-1:0] CTRL_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              o15_rel,
  input  logic              dep_valid,
  input  logic [SLOT_W-1:0] dep_obj,
  input  logic              dep_tx,
  input  logic [IMG_W-1:0]  dep_img,
  output logic              dep_rej
);
  localparam int SLOTS = 1 << SLOT_W;

  dec_t              dec;
  logic [DATA_W-1:0] glob_rd;
  logic [DATA_W-1:0] obj_rd [SLOTS];
  logic [DATA_W-1:0] ctrl_q, bt0_q, bt1_q;
  logic              bt_blocked;
  logic [SLOTS-1:0]  new_vec, lost_vec, ovr_vec;
  logic              o15_vis, o15_vf, o15_pf, o15_lost, o15_swap, o15_dep;
  logic              obj_wr;

  assign dec     = map_addr(cpu_addr);
  assign obj_wr  = cpu_wr && dec.rg == RG_OBJ;
  assign o15_dep = dep_valid && dep_obj == SLOT_W'(OBJ_LAST) && !dep_tx;
  assign dep_rej = dep_valid && dep_obj == SLOT_W'(OBJ_LAST) && dep_tx;

  can_mram_glob #(.CCE_BIT(CCE_BIT), .CTRL_RST(CTRL_RST)) u_glob (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .rg(dec.rg), .byt(dec.byt),
    .wdata(cpu_wdata), .rdata(glob_rd), .ctrl_q(ctrl_q), .bt0_q(bt0_q),
    .bt1_q(bt1_q), .bt_blocked(bt_blocked)
  );

  assign obj_rd[0]   = '0;
  assign new_vec[0]  = 1'b0;
  assign lost_vec[0] = 1'b0;
  assign ovr_vec[0]  = 1'b0;

  for (genvar g = 1; g < OBJ_LAST; g++) begin : g_sobj
    can_mram_sobj u_obj (
      .clk(clk), .rst_n(rst_n),
      .cpu_we(obj_wr && dec.slot == SLOT_W'(g)), .byt(dec.byt), .wdata(cpu_wdata),
      .dep_we(dep_valid && dep_obj == SLOT_W'(g)), .dep_img(dep_img),
      .rdata(obj_rd[g]), .new_o(new_vec[g]), .lost_o(lost_vec[g]), .ovr_ev(ovr_vec[g])
    );
  end

  can_mram_o15 u_o15 (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(obj_wr && dec.slot == SLOT_W'(OBJ_LAST)), .byt(dec.byt), .wdata(cpu_wdata),
    .rel(o15_rel), .dep_we(o15_dep), .dep_img(dep_img),
    .rdata(obj_rd[OBJ_LAST]), .vis_o(o15_vis), .vf_o(o15_vf), .pf_o(o15_pf),
    .lost_o(o15_lost), .swap_ev(o15_swap), .ovr_ev(ovr_vec[OBJ_LAST])
  );

  assign new_vec[OBJ_LAST]  = o15_vf;
  assign lost_vec[OBJ_LAST] = o15_lost;

  always_comb begin
    case (dec.rg)
      RG_OBJ:                        cpu_rdata = obj_rd[dec.slot];
      RG_GLOB, RG_BT0, RG_BT1, RG_INTR: cpu_rdata = glob_rd;
      default:                       cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/can_mram_chk.sv
module can_mram_chk
  import can_mram_pkg::*;
#(
  parameter int CCE_BIT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              o15_rel,
  input logic              dep_valid,
  input logic [SLOT_W-1:0] dep_obj,
  input logic              dep_rej,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] bt0_q,
  input logic [15:0]       new_vec,
  input logic [15:0]       lost_vec,
  input logic              o15_vis,
  input logic              o15_vf,
  input logic              o15_pf,
  input logic              o15_dep
);
  logic rsvd_addr, bt0_wr, sobj_dep;
  assign rsvd_addr = (cpu_addr >= 8'h02 && cpu_addr <= 8'h05) || cpu_addr == 8'h1F ||
                     cpu_addr == 8'h2F || (cpu_addr[3:0] == 4'hF && cpu_addr >= 8'h6F);
  assign bt0_wr    = cpu_wr && cpu_addr == 8'h3F;
  assign sobj_dep  = dep_valid && dep_obj != 4'd0 && dep_obj != 4'd15;

  AST_BT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    bt0_wr && !ctrl_q[CCE_BIT] |=> $stable(bt0_q)); // R4
  AST_BT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    bt0_wr && ctrl_q[CCE_BIT] |=> bt0_q == $past(cpu_wdata)); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_addr |-> cpu_rdata == 8'h00); // R3
  AST_NEW_ON_DEP: assert property (@(posedge clk) disable iff (!rst_n)
    sobj_dep |=> new_vec[$past(dep_obj)]); // R5
  AST_LOST_ON_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    sobj_dep && new_vec[dep_obj] |=> lost_vec[$past(dep_obj)]); // R6
  AST_O15_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    o15_pf |-> o15_vf); // R8
  AST_O15_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    o15_rel && o15_pf && !o15_dep |=> o15_vis != $past(o15_vis) && !o15_pf); // R9
  AST_O15_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
    o15_dep && o15_vf && o15_pf && !o15_rel |=> lost_vec[15] && $stable(o15_vis)); // R10
  AST_O15_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    dep_rej && !o15_rel |=> $stable(o15_vis) && $stable(o15_vf) && $stable(o15_pf)); // R11
endmodule

bind can_msg_ram can_mram_chk #(.CCE_BIT(CCE_BIT)) i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .o15_rel(o15_rel),
  .dep_valid(dep_valid), .dep_obj(dep_obj), .dep_rej(dep_rej),
  .ctrl_q(ctrl_q), .bt0_q(bt0_q), .new_vec(new_vec), .lost_vec(lost_vec),
  .o15_vis(o15_vis), .o15_vf(o15_vf), .o15_pf(o15_pf), .o15_dep(o15_dep)
);

// File: tb/test_can_msg_ram.sv
module test_can_msg_ram;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   cpu_addr = '0;
  logic         cpu_wr = 1'b0;
  logic [7:0]   cpu_wdata = '0;
  logic [7:0]   cpu_rdata;
  logic         o15_rel = 1'b0;
  logic         dep_valid = 1'b0;
  logic [3:0]   dep_obj = '0;
  logic         dep_tx = 1'b0;
  logic [119:0] dep_img = '0;
  logic         dep_rej;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  can_msg_ram i_can_msg_ram (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .o15_rel(o15_rel),
    .dep_valid(dep_valid), .dep_obj(dep_obj), .dep_tx(dep_tx),
    .dep_img(dep_img), .dep_rej(dep_rej)
  );

  function automatic logic [7:0] ib(input logic [7:0] seed, input int k);
    return seed ^ 8'(k * 8'h11);
  endfunction
  function automatic logic [119:0] img(input logic [7:0] seed);
    logic [119:0] r;
    for (int k = 0; k < 15; k++) r[k*8 +: 8] = ib(seed, k);
    return r;
  endfunction
  function automatic logic [7:0] b0(input logic lost, input logic nw, input logic [7:0] raw);
    return {lost, nw, raw[5:0]};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; #1 d = cpu_rdata;
  endtask
  task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d); check(req, d, exp);
  endtask
  task automatic dep(input logic [3:0] o, input logic [7:0] seed, input logic tx);
    @(negedge clk); dep_valid = 1'b1; dep_obj = o; dep_img = img(seed); dep_tx = tx;
    @(negedge clk); dep_valid = 1'b0; dep_tx = 1'b0;
  endtask
  task automatic rel;
    @(negedge clk); o15_rel = 1'b1;
    @(negedge clk); o15_rel = 1'b0;
  endtask

  task automatic t_reset;
    rdchk("R1 ctrl", 8'h00, 8'h01);
    rdchk("R1 status", 8'h01, 8'h00);
    rdchk("R1 bt0", 8'h3F, 8'h00);
    rdchk("R1 obj1 b0", 8'h10, 8'h00);
    rdchk("R1 obj15 b0", 8'hF0, 8'h00);
  endtask

  task automatic t_map;
    wr(8'h01, 8'hA5); wr(8'h07, 8'h3C); wr(8'h0F, 8'hC3);
    wr(8'h7E, 8'h5A); wr(8'hE1, 8'h96);
    rdchk("R2 status", 8'h01, 8'hA5);
    rdchk("R2 smask", 8'h07, 8'h3C);
    rdchk("R2 m15mask", 8'h0F, 8'hC3);
    rdchk("R2 obj7 b14", 8'h7E, 8'h5A);
    rdchk("R2 obj14 b1", 8'hE1, 8'h96);
  endtask

  task automatic t_reserved;
    wr(8'h03, 8'hFF); wr(8'h2F, 8'hEE); wr(8'h9F, 8'hDD); wr(8'hFF, 8'hCC);
    rdchk("R3 0x03", 8'h03, 8'h00);
    rdchk("R3 0x2F", 8'h2F, 8'h00);
    rdchk("R3 0x9F", 8'h9F, 8'h00);
    rdchk("R3 0xFF", 8'hFF, 8'h00);
    rdchk("R3 obj2 b14 untouched", 8'h2E, 8'h00);
  endtask

  task automatic t_bt;
    wr(8'h3F, 8'h12);
    rdchk("R4 bt0 locked", 8'h3F, 8'h00);
    wr(8'h5F, 8'h77);
    rdchk("R4 intr", 8'h5F, 8'h77);
    wr(8'h00, 8'h41); wr(8'h3F, 8'h12); wr(8'h4F, 8'h34);
    rdchk("R4 bt0 open", 8'h3F, 8'h12);
    rdchk("R4 bt1 open", 8'h4F, 8'h34);
    wr(8'h00, 8'h01); wr(8'h4F, 8'h99);
    rdchk("R4 bt1 relocked", 8'h4F, 8'h34);
  endtask

  task automatic t_single;
    dep(4'd2, 8'h20, 1'b0);
    rdchk("R5 b0", 8'h20, b0(1'b0, 1'b1, ib(8'h20, 0)));
    for (int k = 1; k < 15; k++) rdchk("R5 byte", 8'h20 + 8'(k), ib(8'h20, k));
    dep(4'd2, 8'h4B, 1'b0);
    rdchk("R6 b0 lost", 8'h20, b0(1'b1, 1'b1, ib(8'h4B, 0)));
    rdchk("R6 b5", 8'h25, ib(8'h4B, 5));
    wr(8'h20, 8'hBF);
    rdchk("R7 new cleared", 8'h20, 8'hBF);
    wr(8'h20, 8'h45);
    rdchk("R7 lost cleared", 8'h20, 8'h05);
    dep(4'd2, 8'h66, 1'b0);
    rdchk("R6 no loss when read", 8'h20, b0(1'b0, 1'b1, ib(8'h66, 0)));
    dep(4'd3, 8'h81, 1'b1);
    rdchk("R11 tx obj3 accepted", 8'h37, ib(8'h81, 7));
  endtask

  task automatic t_o15;
    dep(4'd15, 8'hA0, 1'b0);
    rdchk("R8 first b0", 8'hF0, b0(1'b0, 1'b1, ib(8'hA0, 0)));
    rdchk("R8 first b3", 8'hF3, ib(8'hA0, 3));
    dep(4'd15, 8'hB0, 1'b0);
    rdchk("R8 still first", 8'hF3, ib(8'hA0, 3));
    rel;
    rdchk("R9 swapped", 8'hF3, ib(8'hB0, 3));
    rdchk("R9 swapped b0", 8'hF0, b0(1'b0, 1'b1, ib(8'hB0, 0)));
    rel;
    rdchk("R9 empty", 8'hF0, b0(1'b0, 1'b0, ib(8'hB0, 0)));
    dep(4'd15, 8'hC0, 1'b0);
    dep(4'd15, 8'hD0, 1'b0);
    dep(4'd15, 8'hE0, 1'b0);
    rdchk("R10 visible kept", 8'hF3, ib(8'hC0, 3));
    rdchk("R10 lost set", 8'hF0, b0(1'b1, 1'b1, ib(8'hC0, 0)));
    rel;
    rdchk("R10 third replaced second", 8'hF3, ib(8'hE0, 3));
    wr(8'hF0, 8'h00);
    rdchk("R10 lost cleared", 8'hF0, 8'h40);
  endtask

  task automatic t_reject;
    @(negedge clk); dep_valid = 1'b1; dep_obj = 4'd15; dep_img = img(8'h5C); dep_tx = 1'b1;
    #1 check("R11 dep_rej", {7'd0, dep_rej}, 8'h01);
    @(negedge clk); dep_valid = 1'b0; dep_tx = 1'b0;
    rdchk("R11 obj15 unchanged", 8'hF3, ib(8'hE0, 3));
    rel;
    rdchk("R11 nothing pending", 8'hF0, 8'h00);
  endtask

  task automatic t_collide;
    @(negedge clk);
    cpu_addr = 8'h43; cpu_wdata = 8'h11; cpu_wr = 1'b1;
    dep_valid = 1'b1; dep_obj = 4'd4; dep_img = img(8'h60); dep_tx = 1'b0;
    @(negedge clk); cpu_wr = 1'b0; dep_valid = 1'b0;
    rdchk("R12 deposit wins", 8'h43, ib(8'h60, 3));
  endtask

  task automatic t_obj0;
    dep(4'd0, 8'h99, 1'b0);
    rdchk("R13 status kept", 8'h01, 8'hA5);
    rdchk("R13 ctrl kept", 8'h00, 8'h01);
    rdchk("R13 smask kept", 8'h07, 8'h3C);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_map;
    t_reserved;
    t_bt;
    t_single;
    t_o15;
    t_reject;
    t_collide;
    t_obj0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule